// File: doc/BRIEF.md
# Banked Video Memory Address Router

This block sits between a processor-side memory port and nine video RAM banks of unequal size. For every request it works out which banks are addressed, gives each bank an address reduced to that bank's own size, raises a write strobe on every addressed bank for a write, and for a read merges the data the banks return into one registered word. The bank storage and the logic that fills the slot tables lie outside the block. The storage is expected to return read data combinationally for the address it is given.

Six views are selected per request. In the direct view each bank sits at a fixed place in a window, and an enable bit per bank gates it. In the five remapped views the address space is cut into slots. A table supplies a nine-bit bank mask for each slot, so one slot may hold several banks at once. A read then returns the OR of all of them, and a write lands in all of them in the same cycle. Each remapped view accepts only a fixed subset of banks, and table bits for any other bank have no effect.

A read is answered one clock after the request, with `rd_valid` high for one cycle per read. Reads may be issued back to back. A small state machine tracks the response. It has two states. ST_IDLE means no read was accepted on the previous edge. ST_READ_RET means a read was accepted and its data is now on `rdata`. A read request in either state moves it to ST_READ_RET. Any other cycle returns it to ST_IDLE.

Top module: `vram_bank_router`

## Requirements
- R1: Direct view (view_sel 0) needs addr[23]=1 and decodes addr[19:14], ignoring addr[22:20], so the window repeats every 1 MiB. Banks 0..3 take codes 0-7, 8-15, 16-23 and 24-31. Bank 4 takes 32-35, bank 5 takes 36, bank 6 takes 37, bank 7 takes 38-39 and bank 8 takes 40.
- R2: In the direct view, a bank whose direct_en bit is clear gets no write strobe and contributes zero to a read. Codes 41-63, and any address with addr[23]=0, reach no bank and read as zero.
- R3: Each remapped view indexes its table with a fixed slot field. Main background (view 1) uses addr[18:14] over 32 slots. Main object (view 2) uses addr[17:14] over 16 slots. Secondary background (3) and secondary object (4) use addr[16:14] over 8 slots. Coprocessor (5) uses addr[17] over 2 slots. Entry k of a table occupies bits [9k+8:9k], and bit b of an entry selects bank b.
- R4: A remapped read returns the bitwise OR of the data of every selected bank. A slot with no bank selected reads zero.
- R5: A remapped write raises bank_we for every selected bank in the request cycle, with bank_wdata equal to wdata.
- R6: Only some banks are valid in each view, and table bits for any other bank are ignored. Main background accepts banks 0-6. Main object accepts 0, 1, 4, 5 and 6. Secondary background accepts 2, 7 and 8. Secondary object accepts 3 and 8. Coprocessor accepts 2 and 3.
- R7: Bank b sees addr modulo its size on bank_addr[17b+16:17b]. The masks are addr[16:0] for banks 0-3, addr[15:0] for bank 4, addr[14:0] for bank 7 and addr[13:0] for banks 5, 6 and 8. Unused upper bits are zero.
- R8: A read request produces rd_valid high and the merged data on rdata one clock later. rd_valid is low in every cycle that does not follow a read request.
- R9: Byte lane l is data bits [8l+7:8l]. A read returns zero in every lane whose be bit is clear. bank_be follows be.
- R10: After reset rd_valid is low and rdata is zero, and bank_we stays zero without a write request.
- R11: View codes 6 and 7 reach no bank. A read returns zero and a write raises no bank_we.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Access request this cycle |
| we | input | 1 | 1 = write, 0 = read |
| view_sel | input | 3 | View code 0..5 (6, 7 unused) |
| addr | input | 24 | Byte address offset within the video region |
| be | input | 4 | Byte lane enables |
| wdata | input | 32 | Write data |
| direct_en | input | 9 | Per-bank enable for the direct view |
| map_main_bg | input | 288 | 32 slot masks, main background view |
| map_main_obj | input | 144 | 16 slot masks, main object view |
| map_sub_bg | input | 72 | 8 slot masks, secondary background view |
| map_sub_obj | input | 72 | 8 slot masks, secondary object view |
| map_coproc | input | 18 | 2 slot masks, coprocessor view |
| bank_rdata | input | 288 | Read data from each bank, 32 bits per bank |
| bank_we | output | 9 | Per-bank write strobe |
| bank_addr | output | 153 | Bank-local byte address, 17 bits per bank |
| bank_be | output | 4 | Byte enables to the banks |
| bank_wdata | output | 32 | Write data to the banks |
| rd_valid | output | 1 | Read data valid |
| rdata | output | 32 | Registered merged read data |

## Verification
The hardest case is an overlap read, where two or more banks answer the same slot and each sees a different local address. The merged word only exposes a wrong OR or a wrong local mask if every bank's contribution can be told apart. The bench's bank model therefore returns a per-bank marker bit above the local address. It programs slots with two and three banks of different sizes, at addresses with mirror bits set, so that each bank's modulo mask shows in the merged word. Disallowed table bits are placed in the very slots being exercised, so an ignored bank would show up as an extra marker bit or an extra write strobe.

// File: rtl/vram_route_pkg.sv
package vram_route_pkg;

    localparam int NUM_BANKS = 9;
    localparam int ADDR_W    = 24;
    localparam int DATA_W    = 32;
    localparam int BE_W      = DATA_W / 8;
    localparam int LOCAL_AW  = 17;

    localparam int SLOTS_MAIN_BG  = 32;
    localparam int SLOTS_MAIN_OBJ = 16;
    localparam int SLOTS_SUB      = 8;
    localparam int SLOTS_COPROC   = 2;

    localparam int SLOT_LSB = 14;

    localparam logic [NUM_BANKS-1:0] ALLOW_MAIN_BG  = 9'h07F;
    localparam logic [NUM_BANKS-1:0] ALLOW_MAIN_OBJ = 9'h073;
    localparam logic [NUM_BANKS-1:0] ALLOW_SUB_BG   = 9'h184;
    localparam logic [NUM_BANKS-1:0] ALLOW_SUB_OBJ  = 9'h108;
    localparam logic [NUM_BANKS-1:0] ALLOW_COPROC   = 9'h00C;

    typedef enum logic [2:0] {
        VIEW_DIRECT   = 3'd0,
        VIEW_MAIN_BG  = 3'd1,
        VIEW_MAIN_OBJ = 3'd2,
        VIEW_SUB_BG   = 3'd3,
        VIEW_SUB_OBJ  = 3'd4,
        VIEW_COPROC   = 3'd5
    } view_e;

    typedef enum logic {
        ST_IDLE     = 1'b0,
        ST_READ_RET = 1'b1
    } rsp_state_e;

    // Local address width of each bank (log2 of its size in bytes).
    function automatic int bank_aw(input int b);
        case (b)
            0, 1, 2, 3: return 17;
            4:          return 16;
            7:          return 15;
            default:    return 14;
        endcase
    endfunction

endpackage

// File: rtl/vr_direct_decode.sv
module vr_direct_decode
    import vram_route_pkg::*;
(
    input  logic                 win_hit,
    input  logic [5:0]           blk_code,
    input  logic [NUM_BANKS-1:0] enable,
    output logic [NUM_BANKS-1:0] sel
);

    localparam logic [5:0] LARGE_BLKS = 6'd32;

    logic [NUM_BANKS-1:0] hit;

    always_comb begin
        hit = '0;
        if (win_hit) begin
            if (blk_code < LARGE_BLKS) begin
                hit[blk_code[4:3]] = 1'b1;
            end else begin
                case (blk_code)
                    6'd32, 6'd33, 6'd34, 6'd35: hit[4] = 1'b1;
                    6'd36:                      hit[5] = 1'b1;
                    6'd37:                      hit[6] = 1'b1;
                    6'd38, 6'd39:               hit[7] = 1'b1;
                    6'd40:                      hit[8] = 1'b1;
                    default:                    hit    = '0;
                endcase
            end
        end
    end

    assign sel = hit & enable;

endmodule

// File: rtl/vr_slot_select.sv
module vr_slot_select
    import vram_route_pkg::*;
(
    input  logic [2:0]                            view_sel,
    input  logic [4:0]                            slot_bits,
    input  logic [SLOTS_MAIN_BG*NUM_BANKS-1:0]    map_main_bg,
    input  logic [SLOTS_MAIN_OBJ*NUM_BANKS-1:0]   map_main_obj,
    input  logic [SLOTS_SUB*NUM_BANKS-1:0]        map_sub_bg,
    input  logic [SLOTS_SUB*NUM_BANKS-1:0]        map_sub_obj,
    input  logic [SLOTS_COPROC*NUM_BANKS-1:0]     map_coproc,
    output logic [NUM_BANKS-1:0]                  sel
);

    localparam int MBG_W = $clog2(SLOTS_MAIN_BG);
    localparam int MOB_W = $clog2(SLOTS_MAIN_OBJ);
    localparam int SUB_W = $clog2(SLOTS_SUB);
    localparam int CPR_W = $clog2(SLOTS_COPROC);

    logic [MBG_W-1:0] s_mbg;
    logic [MOB_W-1:0] s_mob;
    logic [SUB_W-1:0] s_sub;
    logic [CPR_W-1:0] s_cpr;

    assign s_mbg = slot_bits[MBG_W-1:0];
    assign s_mob = slot_bits[MOB_W-1:0];
    assign s_sub = slot_bits[SUB_W-1:0];
    // Coprocessor slots are 128 KiB: the slot bit is address bit 17.
    assign s_cpr = slot_bits[3 +: CPR_W];

    view_e view;
    assign view = view_e'(view_sel);

    always_comb begin
        sel = '0;
        case (view)
            VIEW_MAIN_BG:  sel = map_main_bg[s_mbg*NUM_BANKS +: NUM_BANKS]  & ALLOW_MAIN_BG;
            VIEW_MAIN_OBJ: sel = map_main_obj[s_mob*NUM_BANKS +: NUM_BANKS] & ALLOW_MAIN_OBJ;
            VIEW_SUB_BG:   sel = map_sub_bg[s_sub*NUM_BANKS +: NUM_BANKS]   & ALLOW_SUB_BG;
            VIEW_SUB_OBJ:  sel = map_sub_obj[s_sub*NUM_BANKS +: NUM_BANKS]  & ALLOW_SUB_OBJ;
            VIEW_COPROC:   sel = map_coproc[s_cpr*NUM_BANKS +: NUM_BANKS]   & ALLOW_COPROC;
            default:       sel = '0;
        endcase
    end

endmodule

// File: rtl/vr_bank_addr.sv
module vr_bank_addr
    import vram_route_pkg::*;
(
    input  logic [LOCAL_AW-1:0]           addr_low,
    output logic [NUM_BANKS*LOCAL_AW-1:0] bank_addr
);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int AW = bank_aw(b);
        assign bank_addr[b*LOCAL_AW +: LOCAL_AW] = LOCAL_AW'(addr_low[AW-1:0]);
    end

endmodule

// File: rtl/vr_read_merge.sv
module vr_read_merge
    import vram_route_pkg::*;
(
    input  logic [NUM_BANKS-1:0]        sel,
    input  logic [NUM_BANKS*DATA_W-1:0] bank_rdata,
    input  logic [BE_W-1:0]             be,
    output logic [DATA_W-1:0]           merged
);

    logic [DATA_W-1:0] gated [NUM_BANKS];
    logic [DATA_W-1:0] acc;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_gate
        assign gated[b] = sel[b] ? bank_rdata[b*DATA_W +: DATA_W] : '0;
    end

    always_comb begin
        acc = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            acc = acc | gated[b];
        end
    end

    for (genvar l = 0; l < BE_W; l++) begin : g_lane
        assign merged[l*8 +: 8] = be[l] ? acc[l*8 +: 8] : 8'h00;
    end

endmodule

// File: rtl/vram_bank_router.sv
module vram_bank_router
    import vram_route_pkg::*;
(
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  req,
    input  logic                                  we,
    input  logic [2:0]                            view_sel,
    input  logic [ADDR_W-1:0]                     addr,
    input  logic [BE_W-1:0]                       be,
    input  logic [DATA_W-1:0]                     wdata,
    input  logic [NUM_BANKS-1:0]                  direct_en,
    input  logic [SLOTS_MAIN_BG*NUM_BANKS-1:0]    map_main_bg,
    input  logic [SLOTS_MAIN_OBJ*NUM_BANKS-1:0]   map_main_obj,
    input  logic [SLOTS_SUB*NUM_BANKS-1:0]        map_sub_bg,
    input  logic [SLOTS_SUB*NUM_BANKS-1:0]        map_sub_obj,
    input  logic [SLOTS_COPROC*NUM_BANKS-1:0]     map_coproc,
    input  logic [NUM_BANKS*DATA_W-1:0]           bank_rdata,
    output logic [NUM_BANKS-1:0]                  bank_we,
    output logic [NUM_BANKS*LOCAL_AW-1:0]         bank_addr,
    output logic [BE_W-1:0]                       bank_be,
    output logic [DATA_W-1:0]                     bank_wdata,
    output logic                                  rd_valid,
    output logic [DATA_W-1:0]                     rdata
);

    // addr[22:20] are mirror bits of the direct window.
    logic unused_mirror;
    assign unused_mirror = ^addr[22:20];

    logic [NUM_BANKS-1:0] direct_sel;
    logic [NUM_BANKS-1:0] remap_sel;
    logic [NUM_BANKS-1:0] sel;
    logic [DATA_W-1:0]    merged;
    logic                 rd_req;
    logic                 wr_req;

    rsp_state_e state_q;
    rsp_state_e state_nx;
    logic [DATA_W-1:0] rdata_q;

    vr_direct_decode i_direct (
        .win_hit  (addr[ADDR_W-1]),
        .blk_code (addr[19:SLOT_LSB]),
        .enable   (direct_en),
        .sel      (direct_sel)
    );

    vr_slot_select i_slot (
        .view_sel     (view_sel),
        .slot_bits    (addr[18:SLOT_LSB]),
        .map_main_bg  (map_main_bg),
        .map_main_obj (map_main_obj),
        .map_sub_bg   (map_sub_bg),
        .map_sub_obj  (map_sub_obj),
        .map_coproc   (map_coproc),
        .sel          (remap_sel)
    );

    vr_bank_addr i_baddr (
        .addr_low  (addr[LOCAL_AW-1:0]),
        .bank_addr (bank_addr)
    );

    vr_read_merge i_merge (
        .sel        (sel),
        .bank_rdata (bank_rdata),
        .be         (be),
        .merged     (merged)
    );

    assign sel    = (view_sel == VIEW_DIRECT) ? direct_sel : remap_sel;
    assign rd_req = req & ~we;
    assign wr_req = req & we;

    assign bank_we    = wr_req ? sel : '0;
    assign bank_be    = be;
    assign bank_wdata = wdata;

    // Response state register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    always_comb begin
        state_nx = ST_IDLE;
        unique case (state_q)
            ST_IDLE:     state_nx = rd_req ? ST_READ_RET : ST_IDLE;
            ST_READ_RET: state_nx = rd_req ? ST_READ_RET : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_req) begin
            rdata_q <= merged;
        end
    end

    // Outputs from state.
    always_comb begin
        rd_valid = 1'b0;
        unique case (state_q)
            ST_IDLE:     rd_valid = 1'b0;
            ST_READ_RET: rd_valid = 1'b1;
        endcase
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/vr_router_checker.sv
module vr_router_checker
    import vram_route_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req,
    input logic                 we,
    input logic [2:0]           view_sel,
    input logic [BE_W-1:0]      be,
    input logic [NUM_BANKS-1:0] direct_en,
    input logic [NUM_BANKS-1:0] bank_we,
    input logic                 rd_valid,
    input logic [DATA_W-1:0]    rdata
);

    AST_WE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_we != '0) |-> (req && we)); // R10

    AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we) |=> rd_valid); // R8

    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !(req && !we) |=> !rd_valid); // R8

    AST_DIRECT_SINGLE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we && view_sel == 3'd0) |-> $onehot0(bank_we)); // R1

    AST_DIRECT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we && view_sel == 3'd0) |-> ((bank_we & ~direct_en) == '0)); // R2

    AST_COPROC_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we && view_sel == 3'd5) |-> ((bank_we & ~ALLOW_COPROC) == '0)); // R6

    AST_DEAD_VIEWS: assert property (@(posedge clk) disable iff (!rst_n)
        (view_sel > 3'd5) |-> (bank_we == '0)); // R11

    AST_LANES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (($past(be[0]) || rdata[7:0]   == 8'h00) &&
                      ($past(be[1]) || rdata[15:8]  == 8'h00) &&
                      ($past(be[2]) || rdata[23:16] == 8'h00) &&
                      ($past(be[3]) || rdata[31:24] == 8'h00))); // R9

endmodule

bind vram_bank_router vr_router_checker i_router_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .we        (we),
    .view_sel  (view_sel),
    .be        (be),
    .direct_en (direct_en),
    .bank_we   (bank_we),
    .rd_valid  (rd_valid),
    .rdata     (rdata)
);

// File: tb/test_vram_bank_router.sv
module test_vram_bank_router;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         req;
    logic         we;
    logic [2:0]   view_sel;
    logic [23:0]  addr;
    logic [3:0]   be;
    logic [31:0]  wdata;
    logic [8:0]   direct_en;
    logic [287:0] map_main_bg;
    logic [143:0] map_main_obj;
    logic [71:0]  map_sub_bg;
    logic [71:0]  map_sub_obj;
    logic [17:0]  map_coproc;
    logic [287:0] bank_rdata;
    logic [8:0]   bank_we;
    logic [152:0] bank_addr;
    logic [3:0]   bank_be;
    logic [31:0]  bank_wdata;
    logic         rd_valid;
    logic [31:0]  rdata;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    vram_bank_router i_vram_bank_router (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .view_sel(view_sel),
        .addr(addr), .be(be), .wdata(wdata), .direct_en(direct_en),
        .map_main_bg(map_main_bg), .map_main_obj(map_main_obj),
        .map_sub_bg(map_sub_bg), .map_sub_obj(map_sub_obj),
        .map_coproc(map_coproc), .bank_rdata(bank_rdata),
        .bank_we(bank_we), .bank_addr(bank_addr), .bank_be(bank_be),
        .bank_wdata(bank_wdata), .rd_valid(rd_valid), .rdata(rdata)
    );

    // Bank storage model: marker bit per bank above the local address.
    always_comb begin
        for (int b = 0; b < 9; b++) begin
            bank_rdata[b*32 +: 32] = (32'h1 << (b + 20)) | {15'd0, bank_addr[b*17 +: 17]};
        end
    end

    function automatic logic [16:0] loc(input int b, input logic [23:0] a);
        case (b)
            0, 1, 2, 3: return a[16:0];
            4:          return {1'b0, a[15:0]};
            7:          return {2'b0, a[14:0]};
            default:    return {3'b0, a[13:0]};
        endcase
    endfunction

    function automatic logic [31:0] exp_read(input logic [8:0] m, input logic [23:0] a,
                                             input logic [3:0] lanes);
        logic [31:0] d;
        d = '0;
        for (int b = 0; b < 9; b++) begin
            if (m[b]) d = d | (32'h1 << (b + 20)) | {15'd0, loc(b, a)};
        end
        for (int l = 0; l < 4; l++) begin
            if (!lanes[l]) d[l*8 +: 8] = 8'h00;
        end
        return d;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_read(input logic [2:0] v, input logic [23:0] a, input logic [3:0] lanes,
                           input logic [8:0] m, input string tag);
        @(negedge clk);
        req = 1'b1; we = 1'b0; view_sel = v; addr = a; be = lanes;
        exp_q.push_back(exp_read(m, a, lanes));
        tag_q.push_back(tag);
    endtask

    task automatic do_write(input logic [2:0] v, input logic [23:0] a, input logic [3:0] lanes,
                            input logic [31:0] d, input logic [8:0] m, input string tag);
        @(negedge clk);
        req = 1'b1; we = 1'b1; view_sel = v; addr = a; be = lanes; wdata = d;
        #1;
        chk({tag, " bank_we"}, 32'(bank_we), 32'(m));
        for (int b = 0; b < 9; b++) begin
            if (m[b]) chk({tag, " R7 bank_addr"}, 32'(bank_addr[b*17 +: 17]), 32'(loc(b, a)));
        end
        chk({tag, " R5 bank_wdata"}, bank_wdata, d);
        chk({tag, " R9 bank_be"}, 32'(bank_be), 32'(lanes));
    endtask

    task automatic idle();
        @(negedge clk);
        req = 1'b0; we = 1'b0;
    endtask

    // Scoreboard monitor.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                chk("R8 unexpected rd_valid", 32'd1, 32'd0);
            end else begin
                chk(tag_q.pop_front(), rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        #2000000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req = 1'b0; we = 1'b0; view_sel = 3'd0; addr = '0;
        be = 4'hF; wdata = '0; direct_en = 9'h1FF;
        map_main_bg = '0; map_main_obj = '0; map_sub_bg = '0; map_sub_obj = '0; map_coproc = '0;
        map_main_bg[3*9 +: 9]  = 9'h005;
        map_main_bg[31*9 +: 9] = 9'h140;
        map_main_obj[15*9 +: 9] = 9'h034;
        map_sub_bg[2*9 +: 9]   = 9'h184;
        map_sub_obj[7*9 +: 9]  = 9'h1FF;
        map_coproc[0*9 +: 9]   = 9'h004;
        map_coproc[1*9 +: 9]   = 9'h1FF;

        repeat (3) @(negedge clk);
        chk("R10 reset rd_valid", 32'(rd_valid), 32'd0);
        chk("R10 reset rdata", rdata, 32'd0);
        chk("R10 reset bank_we", 32'(bank_we), 32'd0);
        rst_n = 1'b1;

        // Direct view, all banks on, back-to-back reads.
        do_read(3'd0, 24'h801234, 4'hF, 9'h001, "R1 bank0");
        do_read(3'd0, 24'h83C010, 4'hF, 9'h002, "R1 bank1");
        do_read(3'd0, 24'h840000, 4'hF, 9'h004, "R1 bank2");
        do_read(3'd0, 24'h870004, 4'hF, 9'h008, "R1 bank3");
        do_read(3'd0, 24'h88C008, 4'hF, 9'h010, "R1 bank4");
        do_read(3'd0, 24'h890010, 4'hF, 9'h020, "R1 bank5");
        do_read(3'd0, 24'h894020, 4'hF, 9'h040, "R1 bank6");
        do_read(3'd0, 24'h89C000, 4'hF, 9'h080, "R1 bank7");
        do_read(3'd0, 24'h8A0100, 4'hF, 9'h100, "R1 bank8");
        do_read(3'd0, 24'h9A0100, 4'hF, 9'h100, "R1 mirror bank8");
        do_read(3'd0, 24'hF90010, 4'hF, 9'h020, "R1 mirror bank5");
        do_read(3'd0, 24'h8A4000, 4'hF, 9'h000, "R2 out of range");
        do_read(3'd0, 24'h0A0100, 4'hF, 9'h000, "R2 below window");
        idle();
        idle();
        chk("R8 idle rd_valid", 32'(rd_valid), 32'd0);

        // Direct view with bank 5 disabled.
        direct_en = 9'h1DF;
        do_read(3'd0, 24'h890010, 4'hF, 9'h000, "R2 disabled read");
        do_write(3'd0, 24'h890010, 4'hF, 32'hA5A5_0001, 9'h000, "R2 disabled write");
        do_write(3'd0, 24'h88C008, 4'hF, 32'hA5A5_0002, 9'h010, "R7 direct bank4 write");
        idle();
        idle();
        chk("R8 no valid after write", 32'(rd_valid), 32'd0);

        // Remapped views.
        do_read(3'd1, 24'h00C100, 4'hF, 9'h005, "R4 overlap main bg");
        do_read(3'd1, 24'h07C004, 4'hF, 9'h040, "R6 main bg slot31");
        do_read(3'd1, 24'h014000, 4'hF, 9'h000, "R4 empty slot");
        do_write(3'd1, 24'h00C100, 4'hF, 32'h1234_5678, 9'h005, "R5 overlap write");
        do_read(3'd2, 24'h07C002, 4'hF, 9'h030, "R3 main obj slot15");
        do_write(3'd2, 24'h07C002, 4'hF, 32'h0BAD_F00D, 9'h030, "R6 main obj write");
        do_read(3'd3, 24'h0C8800, 4'hF, 9'h184, "R4 sub bg three banks");
        do_read(3'd4, 24'h01C000, 4'hF, 9'h108, "R6 sub obj read");
        do_write(3'd4, 24'h01C000, 4'hF, 32'h0000_00FF, 9'h108, "R6 sub obj write");
        do_write(3'd5, 24'h020040, 4'hF, 32'hCAFE_0000, 9'h00C, "R6 coproc write");
        do_read(3'd5, 24'h020040, 4'hF, 9'h00C, "R6 coproc read");
        do_read(3'd5, 24'h000040, 4'hF, 9'h004, "R3 coproc slot0");

        // Byte lanes.
        do_read(3'd0, 24'h8A0100, 4'b0010, 9'h100, "R9 lane1 read");
        do_read(3'd1, 24'h00C100, 4'b1100, 9'h005, "R9 upper lanes read");
        do_write(3'd0, 24'h88C008, 4'b1100, 32'hFFFF_0000, 9'h010, "R9 half write");

        // Unused view codes.
        do_read(3'd6, 24'h00C100, 4'hF, 9'h000, "R11 view6 read");
        do_write(3'd7, 24'h00C100, 4'hF, 32'h1111_1111, 9'h000, "R11 view7 write");
        idle();
        idle();
        idle();
        chk("R8 scoreboard drained", 32'(exp_q.size()), 32'd0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule